// File: doc/BRIEF.md
# Hashed Multibank Request Scheduler

This block accepts memory requests from many hardware threads and spreads them over eight independently timed DRAM banks. Each request names an object and an index within it. A combinational hash of the two picks the bank and the location inside the bank, so no page table or translation cache is needed. The request then waits in a small queue that belongs to its bank.

Every cycle, the scheduler looks at the banks whose queue holds work and whose previous access has finished. A rotating pointer picks one of them, and that bank's oldest request is issued. Requests to different banks therefore overtake one another freely, while requests to the same bank keep their arrival order. For a read, the thread tag comes back on the response port when the bank's fixed busy time is about to end. Writes produce no response.

Top module: `hashed_bank_sched`

## Requirements
- R1: The hash value is the low 16 bits of (index × 0x9E37) XOR object. Bits [2:0] of the hash are the bank, and bits [15:3] are the 13-bit location driven on `mem_iss_addr`.
- R2: `req_ready` is low exactly when the bank chosen by the hash of the presented request already holds 8 queued entries. The count used is the one before any issue in that same cycle.
- R3: After a bank has been issued a request, it receives no further issue until `BUSY_CYCLES` (default 4) cycles later.
- R4: At most one request is issued per cycle. The bank chosen is the first eligible bank at or after the rotating pointer, in increasing bank order with wrap. After each issue, the pointer moves to one past the granted bank.
- R5: A request whose bank is free is issued ahead of older requests that wait on busy banks.
- R6: Requests to the same bank are issued in the order they were accepted, with their tag and write flag unchanged.
- R7: A read issued in cycle k produces `rsp_valid` with its tag in cycle k+`BUSY_CYCLES`-1. A write produces no response. At most one response occurs per cycle.
- R8: During and right after reset, there is no issue and no response, `req_ready` is high, and the pointer starts at bank 0.
- R9: In any cycle where some bank has a queued request and has finished its previous access, an issue takes place. The earliest issue comes one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_obj | input | 16 | Object reference |
| req_idx | input | 16 | Index within the object |
| req_tag | input | 6 | Thread tag |
| mem_iss_valid | output | 1 | A bank access starts this cycle |
| mem_iss_bank | output | 3 | Bank of the access |
| mem_iss_addr | output | 13 | Location inside the bank |
| mem_iss_write | output | 1 | Access is a write |
| mem_iss_tag | output | 6 | Tag of the access |
| rsp_valid | output | 1 | Read completion |
| rsp_tag | output | 6 | Tag of the completed read |

## Verification
The embedded properties rely on the requester keeping its request on the port until `req_ready` is seen high, with the fields stable meanwhile. The stimulus follows this rule: once a request has been presented, it is repeated unchanged every cycle until it is accepted. The properties also assume `BUSY_CYCLES` is at least 2 and that the bank count is a power of two. The bench never overrides either default.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    localparam int          HBS_NUM_BANKS   = 8;
    localparam int          HBS_QUEUE_DEPTH = 8;
    localparam int          HBS_BUSY_CYCLES = 4;
    localparam int          HBS_TAG_W       = 6;
    localparam int          HBS_OBJ_W       = 16;
    localparam int          HBS_IDX_W       = 16;
    localparam int          HBS_LOC_W       = 13;
    localparam int unsigned HBS_HASH_MULT   = 32'h0000_9E37;
endpackage

// File: rtl/hbs_hash.sv
module hbs_hash #(
    parameter int          OBJ_W  = 16,
    parameter int          IDX_W  = 16,
    parameter int          BANK_W = 3,
    parameter int          LOC_W  = 13,
    parameter int unsigned MULT   = 32'h0000_9E37
) (
    input  logic [OBJ_W-1:0]  obj,
    input  logic [IDX_W-1:0]  idx,
    output logic [BANK_W-1:0] bank,
    output logic [LOC_W-1:0]  loc
);
    localparam int HASH_W = BANK_W + LOC_W;

    logic [HASH_W-1:0] idx_ext;
    logic [HASH_W-1:0] mult_c;
    logic [HASH_W-1:0] mixed;

    always_comb begin
        idx_ext = HASH_W'(idx);
        mult_c  = HASH_W'(MULT);
        // the multiply is truncated to the hash width, i.e. modulo 2^HASH_W
        mixed   = (idx_ext * mult_c) ^ HASH_W'(obj);
        bank    = mixed[BANK_W-1:0];
        loc     = mixed[HASH_W-1:BANK_W];
    end
endmodule

// File: rtl/hbs_bank_queue.sv
module hbs_bank_queue #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t             st_d, st_q;
    logic [WIDTH-1:0] store_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop)  st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[st_q.wr] <= push_data;
    end

    assign head  = store_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/hbs_rr_pick.sv
module hbs_rr_pick #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] ptr,
    output logic [N-1:0]         gnt,
    output logic                 any,
    output logic [$clog2(N)-1:0] gidx
);
    localparam int IW = $clog2(N);

    always_comb begin
        int cand;
        gnt  = '0;
        any  = 1'b0;
        gidx = '0;
        cand = 0;
        for (int off = 0; off < N; off++) begin
            cand = (int'(ptr) + off) % N;
            if (!any && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                gidx      = IW'(cand);
            end
        end
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R4
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R9
    grant_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> any);
endmodule

// File: rtl/hashed_bank_sched.sv
module hashed_bank_sched #(
    parameter int          NUM_BANKS   = hbs_pkg::HBS_NUM_BANKS,
    parameter int          QUEUE_DEPTH = hbs_pkg::HBS_QUEUE_DEPTH,
    parameter int          BUSY_CYCLES = hbs_pkg::HBS_BUSY_CYCLES,
    parameter int          OBJ_W       = hbs_pkg::HBS_OBJ_W,
    parameter int          IDX_W       = hbs_pkg::HBS_IDX_W,
    parameter int          LOC_W       = hbs_pkg::HBS_LOC_W,
    parameter int          TAG_W       = hbs_pkg::HBS_TAG_W,
    parameter int unsigned HASH_MULT   = hbs_pkg::HBS_HASH_MULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [OBJ_W-1:0]             req_obj,
    input  logic [IDX_W-1:0]             req_idx,
    input  logic [TAG_W-1:0]             req_tag,
    output logic                         mem_iss_valid,
    output logic [$clog2(NUM_BANKS)-1:0] mem_iss_bank,
    output logic [LOC_W-1:0]             mem_iss_addr,
    output logic                         mem_iss_write,
    output logic [TAG_W-1:0]             mem_iss_tag,
    output logic                         rsp_valid,
    output logic [TAG_W-1:0]             rsp_tag
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(BUSY_CYCLES);
    localparam int ENT_W  = 1 + TAG_W + LOC_W;

    typedef struct packed {
        logic [NUM_BANKS-1:0][CNT_W-1:0] left;
        logic [NUM_BANKS-1:0]            rd_pend;
        logic [NUM_BANKS-1:0][TAG_W-1:0] rd_tag;
        logic [BANK_W-1:0]               rr_ptr;
    } sched_st_t;

    sched_st_t          st_d, st_q;
    logic [BANK_W-1:0]  h_bank;
    logic [LOC_W-1:0]   h_loc;
    logic [NUM_BANKS-1:0] q_push, q_empty, q_full, elig, gnt, fire;
    logic [ENT_W-1:0]   q_head [NUM_BANKS];
    logic [ENT_W-1:0]   new_ent;
    logic [ENT_W-1:0]   sel_ent;
    logic               g_any;
    logic [BANK_W-1:0]  g_idx;

    hbs_hash #(
        .OBJ_W(OBJ_W), .IDX_W(IDX_W), .BANK_W(BANK_W), .LOC_W(LOC_W), .MULT(HASH_MULT)
    ) u_hash (
        .obj(req_obj), .idx(req_idx), .bank(h_bank), .loc(h_loc)
    );

    assign new_ent   = {req_write, req_tag, h_loc};
    assign req_ready = !q_full[h_bank];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign q_push[b] = req_valid && req_ready && (h_bank == BANK_W'(b));
        assign elig[b]   = !q_empty[b] && (st_q.left[b] == '0);

        hbs_bank_queue #(.WIDTH(ENT_W), .DEPTH(QUEUE_DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[b]), .push_data(new_ent), .pop(gnt[b]),
            .head(q_head[b]), .empty(q_empty[b]), .full(q_full[b])
        );
    end

    hbs_rr_pick #(.N(NUM_BANKS)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(elig), .ptr(st_q.rr_ptr),
        .gnt(gnt), .any(g_any), .gidx(g_idx)
    );

    assign sel_ent       = q_head[g_idx];
    assign mem_iss_valid = g_any;
    assign mem_iss_bank  = g_idx;
    assign mem_iss_write = sel_ent[ENT_W-1];
    assign mem_iss_tag   = sel_ent[ENT_W-2 -: TAG_W];
    assign mem_iss_addr  = sel_ent[LOC_W-1:0];

    always_comb begin
        st_d      = st_q;
        fire      = '0;
        rsp_valid = 1'b0;
        rsp_tag   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            fire[b] = st_q.rd_pend[b] && (st_q.left[b] == CNT_W'(1));
            if (fire[b]) begin
                rsp_valid = 1'b1;
                rsp_tag   = st_q.rd_tag[b];
            end
            if (gnt[b]) begin
                st_d.left[b]    = CNT_W'(BUSY_CYCLES - 1);
                st_d.rd_pend[b] = !q_head[b][ENT_W-1];
                st_d.rd_tag[b]  = q_head[b][ENT_W-2 -: TAG_W];
            end else if (st_q.left[b] != '0) begin
                st_d.left[b] = st_q.left[b] - 1'b1;
                if (st_q.left[b] == CNT_W'(1)) st_d.rd_pend[b] = 1'b0;
            end
        end
        if (g_any)
            st_d.rr_ptr = (g_idx == BANK_W'(NUM_BANKS - 1)) ? '0 : g_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_iss_valid |=> !(mem_iss_valid && mem_iss_bank == $past(mem_iss_bank)));
    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));
    // R7
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_iss_valid && mem_iss_write) |=> !(st_q.rd_pend[$past(mem_iss_bank)]));
endmodule

// File: tb/sim_hashed_bank_sched.sv
module sim_hashed_bank_sched;
    localparam int NB = 8, DEPTH = 8, BUSY = 4;
    localparam int MULT = 'h9E37;

    logic clk = 1'b0;
    always #2.5ns clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write;
    logic [15:0] req_obj, req_idx;
    logic [5:0]  req_tag;
    logic        mem_iss_valid, mem_iss_write, rsp_valid;
    logic [2:0]  mem_iss_bank;
    logic [12:0] mem_iss_addr;
    logic [5:0]  mem_iss_tag, rsp_tag;

    hashed_bank_sched u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_obj(req_obj), .req_idx(req_idx), .req_tag(req_tag),
        .mem_iss_valid(mem_iss_valid), .mem_iss_bank(mem_iss_bank),
        .mem_iss_addr(mem_iss_addr), .mem_iss_write(mem_iss_write),
        .mem_iss_tag(mem_iss_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag)
    );

    typedef struct { int loc; bit wr; int tag; } ent_t;
    ent_t q[NB][$];
    int   busy[NB];
    bit   pend[NB];
    int   ptag[NB];
    int   last_iss[NB];
    int   ptr, cyc, checks, errors;
    int   order[$];
    bit   saw_stall;
    int   obs_bank, obs_addr;
    bit   s_valid, s_wr;
    int   s_obj, s_idx, s_tag;

    function automatic int hval(int obj, int idx);
        return ((idx * MULT) ^ obj) & 'hFFFF;
    endfunction

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic step(output bit accepted);
        int  b, g, c, er;
        bit  exp_ready;
        ent_t e;
        @(negedge clk);
        req_valid = s_valid; req_write = s_wr;
        req_obj = s_obj[15:0]; req_idx = s_idx[15:0]; req_tag = s_tag[5:0];
        #1ns;
        b = hval(s_obj, s_idx) & 7;
        exp_ready = q[b].size() < DEPTH;
        // R2
        chk(req_ready == exp_ready, "R2", int'(req_ready), int'(exp_ready));
        if (s_valid && !req_ready) saw_stall = 1;
        g = -1;
        for (int off = 0; off < NB; off++) begin
            c = (ptr + off) % NB;
            if (g < 0 && q[c].size() > 0 && busy[c] == 0) g = c;
        end
        // R9
        chk(mem_iss_valid == (g >= 0), "R9", int'(mem_iss_valid), int'(g >= 0));
        if (g >= 0 && mem_iss_valid) begin
            e = q[g][0];
            chk(int'(mem_iss_bank) == g, "R4", int'(mem_iss_bank), g);
            chk(int'(mem_iss_addr) == e.loc, "R1", int'(mem_iss_addr), e.loc);
            chk(int'(mem_iss_tag) == e.tag, "R6", int'(mem_iss_tag), e.tag);
            chk(mem_iss_write == e.wr, "R6", int'(mem_iss_write), int'(e.wr));
            chk(cyc - last_iss[g] >= BUSY, "R3", cyc - last_iss[g], BUSY);
            last_iss[g] = cyc;
            order.push_back(int'(mem_iss_tag));
            obs_bank = int'(mem_iss_bank); obs_addr = int'(mem_iss_addr);
        end
        er = -1;
        for (int k = 0; k < NB; k++) if (busy[k] == 1 && pend[k]) er = k;
        // R7
        chk(rsp_valid == (er >= 0), "R7", int'(rsp_valid), int'(er >= 0));
        if (er >= 0 && rsp_valid) chk(int'(rsp_tag) == ptag[er], "R7", int'(rsp_tag), ptag[er]);
        accepted = s_valid && exp_ready;
        @(posedge clk);
        for (int k = 0; k < NB; k++) begin
            if (k == g) begin
                busy[k] = BUSY - 1; pend[k] = !q[k][0].wr; ptag[k] = q[k][0].tag;
            end else if (busy[k] > 0) begin
                if (busy[k] == 1) pend[k] = 0;
                busy[k]--;
            end
        end
        if (g >= 0) begin
            void'(q[g].pop_front());
            ptr = (g + 1) % NB;
        end
        if (accepted) begin
            e.loc = hval(s_obj, s_idx) >> 3; e.wr = s_wr; e.tag = s_tag;
            q[b].push_back(e);
        end
        cyc++;
    endtask

    task automatic send(bit wr, int obj, int idx, int tag);
        bit acc;
        s_valid = 1; s_wr = wr; s_obj = obj; s_idx = idx; s_tag = tag;
        do step(acc); while (!acc);
        s_valid = 0;
    endtask

    task automatic idle(int n);
        bit acc;
        s_valid = 0;
        for (int i = 0; i < n; i++) step(acc);
    endtask

    function automatic int obj_for(int bank, int idx, int hi);
        return (((idx * MULT) & 'hFFFF) ^ ((hi << 3) | bank)) & 'hFFFF;
    endfunction

    initial begin
        #1ms;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p11, p13;
        bit acc;
        checks = 0; errors = 0; cyc = 0; ptr = 0; saw_stall = 0;
        for (int k = 0; k < NB; k++) begin busy[k] = 0; pend[k] = 0; last_iss[k] = -1000; end
        s_valid = 0; s_wr = 0; s_obj = 0; s_idx = 0; s_tag = 0;
        rst_n = 0; req_valid = 0; req_write = 0; req_obj = 0; req_idx = 0; req_tag = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(mem_iss_valid == 0, "R8", int'(mem_iss_valid), 0);
        chk(rsp_valid == 0, "R8", int'(rsp_valid), 0);
        chk(req_ready == 1, "R8", int'(req_ready), 1);
        rst_n = 1;
        idle(2);

        // R1 known hash: obj 0, idx 1 -> 0x9E37, bank 7, location 0x13C6
        send(0, 0, 1, 1);
        idle(1);
        chk(obs_bank == 7, "R1", obs_bank, 7);
        chk(obs_addr == 'h13C6, "R1", obs_addr, 'h13C6);
        idle(6);

        // R5 out-of-order: three to bank 0, then one to bank 1
        order.delete();
        send(0, obj_for(0, 5, 1), 5, 10);
        send(0, obj_for(0, 6, 2), 6, 11);
        send(1, obj_for(0, 7, 3), 7, 12);
        send(0, obj_for(1, 8, 4), 8, 13);
        idle(16);
        p11 = -1; p13 = -1;
        foreach (order[i]) begin
            if (order[i] == 11) p11 = i;
            if (order[i] == 13) p13 = i;
        end
        chk(p13 >= 0 && p13 < p11, "R5", p13, p11);

        // R2 backpressure: twenty requests into bank 2
        for (int i = 0; i < 20; i++) send(i % 3 == 0, obj_for(2, 100 + i, i), 100 + i, 20 + i);
        chk(saw_stall, "R2", int'(saw_stall), 1);
        idle(100);

        // random traffic for R4, R6, R7, R9
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) < 3) idle(1);
            else send($urandom_range(0, 3) == 0, $urandom_range(0, 'hFFFF),
                      $urandom_range(0, 'hFFFF), $urandom_range(0, 63));
        end
        idle(300);
        for (int k = 0; k < NB; k++) chk(q[k].size() == 0, "R9", q[k].size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule